// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial characters. It has two storage stages. A one-byte holding register takes writes from the host. A separate frame shifter drives the line. As soon as the shifter is idle and transmission is allowed, the held byte moves into the shifter. That frees the holding register, so the host can queue the next byte while the current one is still going out.

Bit timing does not come from the system clock. It comes from a transmit-clock tick input, and each bit lasts 1, 16 or 64 ticks as selected by a rate field. A new character starts only while the clear-to-send input (active low) is asserted and the command-level transmit enable is set. A character already on the line always completes. Even parity can be inserted between the data and the stop bit. A write that arrives while the holding register is still occupied is discarded and raises a sticky overrun flag.

Top module: `serial_tx_dbuf`

## Requirements
- R1: A synchronous active-high `rst` abandons any character in progress. After reset, `txd`=1, `tx_ready`=1 and `overrun`=0.
- R2: `tx_ready` is 1 exactly while the holding register is empty. A write (`wr_en`=1) accepted while `tx_ready`=1 makes `tx_ready` read 0 in the following cycle.
- R3: When the shifter is idle and the gate of R6 is open, a held byte moves into the shifter on the next clock. `tx_ready` then returns to 1 while that character's start bit is on `txd`.
- R4: The line idles at 1. A character is a start bit (0), then 8 data bits LSB first, then, when `par_en`=1, an even-parity bit (data plus parity holds an even number of ones), then one stop bit (1).
- R5: Each bit lasts exactly N `tx_tick` pulses. `rate_sel` selects N: 2'b00 gives 1, 2'b01 gives 16, and 2'b10 or 2'b11 give 64. `rate_sel` and `par_en` are captured when a character starts.
- R6: A character starts only while `cts_n`=0 and `tx_en`=1. Otherwise the byte stays held, `tx_ready` stays 0 and `txd` stays 1.
- R7: If `cts_n` rises in the middle of a character, that character still completes. No following character starts until `cts_n` is 0 again.
- R8: A write while `tx_ready`=0 is ignored: the held byte is kept and no extra character is sent. The write sets `overrun`, which stays 1 until reset.
- R9: Bit timing advances only on `tx_tick`. Without ticks, `txd` holds its current bit for any number of system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_en | input | 1 | Command-level transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| rate_sel | input | 2 | Ticks-per-bit select: 00 gives 1x, 01 gives 16x, 1x gives 64x |
| par_en | input | 1 | Insert an even-parity bit |
| tx_tick | input | 1 | One-cycle pulse from the transmit-clock domain |
| tx_ready | output | 1 | Holding register empty |
| overrun | output | 1 | Sticky flag: a write was dropped |
| txd | output | 1 | Serial line output |

## Verification
The hardest situation to reach is the one where clear-to-send drops partway through a character while a second byte is already waiting. To reach it, the bench queues two bytes at the 16x rate and watches its own line decoder. Once the decoder is well past the start bit, the bench raises `cts_n`. It then confirms three things: the first character decodes intact, the line stays high for hundreds of cycles, and the second byte stays held. A dropped write is reached by closing the enable gate so the holding register stays full, then forcing a write. Reset in the middle of a character is exercised at the 64x rate.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_W    = DATA_W + 3;
  localparam int unsigned MAX_FACTOR = 64;
  localparam int unsigned MID_FACTOR = 16;
  localparam int unsigned CNT_W      = $clog2(MAX_FACTOR);
  localparam int unsigned LEFT_W     = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X16 = 2'd1,
    RATE_X64 = 2'd2,
    RATE_X64B = 2'd3
  } rate_e;

  // last tick index within one bit period
  function automatic logic [CNT_W-1:0] bit_limit(input logic [1:0] sel);
    case (rate_e'(sel))
      RATE_X1:  return '0;
      RATE_X16: return CNT_W'(MID_FACTOR - 1);
      default:  return CNT_W'(MAX_FACTOR - 1);
    endcase
  endfunction

  function automatic logic even_bit(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  // bit 0 leaves first; unused top bit stays at mark level
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                    input logic par_on);
    return {1'b1, (par_on ? even_bit(d) : 1'b1), d, 1'b0};
  endfunction

  function automatic logic [LEFT_W-1:0] last_index(input logic par_on);
    return par_on ? LEFT_W'(FRAME_W - 1) : LEFT_W'(FRAME_W - 2);
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         buf_full,
  output logic [W-1:0] buf_data,
  output logic         overrun,
  output logic         wr_drop
);
  logic wr_ok;

  assign wr_ok   = wr_en & ~buf_full;
  assign wr_drop = wr_en & buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_data <= '0;
      overrun  <= 1'b0;
    end else begin
      if (wr_ok) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
      end else if (take) begin
        buf_full <= 1'b0;
      end
      if (wr_drop) overrun <= 1'b1;
    end
  end

  p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    wr_drop |=> $stable(buf_data) && overrun);
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  p_take_frees_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> !buf_full);
  p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
    buf_full && !take |=> buf_full && $stable(buf_data));
endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk
  import sertx_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       busy,
  input  logic       tx_tick,
  input  logic [1:0] rate_sel,
  output logic       bit_done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign bit_done = busy & tx_tick & (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= '0;
    end else if (start) begin
      cnt <= '0;
      lim <= bit_limit(rate_sel);
    end else if (busy && tx_tick) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= lim);
  p_no_tick_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !tx_tick && !start |=> $stable(cnt));
  p_rate_held_r5: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(lim));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned FW = FRAME_W,
  parameter int unsigned LW = LEFT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         par_on,
  input  logic         bit_done,
  output logic         busy,
  output logic         txd,
  output logic         frame_end
);
  logic [FW-1:0] sr;
  logic [LW-1:0] left;

  assign frame_end = bit_done & (left == '0);
  assign txd       = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sr   <= '1;
      left <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sr   <= pack_frame(load_data, par_on);
      left <= last_index(par_on);
    end else if (bit_done) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        sr   <= {1'b1, sr[FW-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  p_stop_high_r4: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> txd);
  p_load_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic [1:0]        rate_sel,
  input  logic              par_en,
  input  logic              tx_tick,
  output logic              tx_ready,
  output logic              overrun,
  output logic              txd
);
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              wr_drop;
  logic              gate_open;
  logic              take;
  logic              busy;
  logic              bit_done;
  logic              frame_end;

  assign gate_open = tx_en & ~cts_n;
  assign take      = buf_full & ~busy & gate_open;
  assign tx_ready  = ~buf_full;

  sertx_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .buf_full(buf_full), .buf_data(buf_data), .overrun(overrun), .wr_drop(wr_drop)
  );

  sertx_bitclk #(.CW(CNT_W)) u_bitclk (
    .clk(clk), .rst(rst), .start(take), .busy(busy), .tx_tick(tx_tick),
    .rate_sel(rate_sel), .bit_done(bit_done)
  );

  sertx_shift #(.W(DATA_W), .FW(FRAME_W), .LW(LEFT_W)) u_shift (
    .clk(clk), .rst(rst), .load(take), .load_data(buf_data), .par_on(par_en),
    .bit_done(bit_done), .busy(busy), .txd(txd), .frame_end(frame_end)
  );

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_en && !cts_n));
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && tx_ready |=> !tx_ready);
  p_ends_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tx_tick));
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> txd && tx_ready && !overrun);
endmodule

// File: tb/serial_tx_dbuf_test.sv
module serial_tx_dbuf_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_en = 1'b1;
  logic       cts_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       par_en = 1'b0;
  logic       tx_tick = 1'b0;
  logic       tx_ready, overrun, txd;

  serial_tx_dbuf uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .cts_n(cts_n), .rate_sel(rate_sel), .par_en(par_en), .tx_tick(tx_tick),
    .tx_ready(tx_ready), .overrun(overrun), .txd(txd)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int tick_div = 1;
  logic [7:0] expq [0:2047];
  int wr_i = 0;
  int rd_i = 0;
  int cfg_n = 1;
  bit cfg_par = 1'b0;
  bit m_act = 1'b0;
  int m_pos = 0;
  logic [10:0] m_bits;
  bit m_bad;

  function automatic int factor_of(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 16;
    return 64;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // tick source: one pulse every tick_div clocks, none when 0
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      #1;
      if (tick_div == 0) begin
        tx_tick = 1'b0;
        c = 0;
      end else begin
        tx_tick = (c == 0);
        c = (c + 1) % tick_div;
      end
    end
  end

  task automatic frame_done(input int flen);
    logic [7:0]  e;
    logic [10:0] ef;
    if (rd_i == wr_i) begin
      chk(1'b0, "R8", "unexpected character", int'(m_bits), 0);
    end else begin
      e  = expq[rd_i];
      ef = {1'b1, (cfg_par ? ^e : 1'b1), e, 1'b0};
      chk(!m_bad && m_bits == ef, "R4", "character bits (R5 bit length)",
          int'(m_bits), int'(ef));
      rd_i++;
    end
    if (flen == 0) n_chk = n_chk;
  endtask

  // line decoder: samples txd at each tick, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        m_act = 1'b0;
      end else if (tx_tick) begin
        if (!m_act && txd == 1'b0) begin
          m_act = 1'b1;
          m_pos = 0;
          m_bits = '1;
          m_bad = 1'b0;
        end
        if (m_act) begin
          int bi;
          int flen;
          bi = m_pos / cfg_n;
          flen = cfg_par ? 11 : 10;
          if (m_pos % cfg_n == 0) m_bits[bi] = txd;
          else if (m_bits[bi] !== txd) m_bad = 1'b1;
          m_pos++;
          if (m_pos == flen * cfg_n) begin
            m_act = 1'b0;
            frame_done(flen);
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    while (!tx_ready) step;
    wr_en = 1'b1;
    wr_data = b;
    expq[wr_i] = b;
    wr_i++;
    step;
    wr_en = 1'b0;
  endtask

  task automatic drain;
    while (rd_i != wr_i || !tx_ready || m_act) step;
    repeat (4) step;
  endtask

  task automatic set_rate(input logic [1:0] s);
    rate_sel = s;
    cfg_n = factor_of(s);
  endtask

  task automatic hold_check(input int cycles, input string tag);
    int bad;
    int r0;
    bad = 0;
    r0 = rd_i;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_ready !== 1'b0) bad++;
    end
    chk(bad == 0 && rd_i == r0, tag, "held byte while gate closed", bad, 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    int r0;
    // R1: reset state
    rst = 1'b1;
    repeat (3) step;
    @(negedge clk);
    chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(tx_ready === 1'b1, "R1", "tx_ready in reset", int'(tx_ready), 1);
    chk(overrun === 1'b0, "R1", "overrun in reset", int'(overrun), 0);
    step;
    rst = 1'b0;
    step;

    // R2 / R3: handoff timing
    wr_en = 1'b1;
    wr_data = 8'hA5;
    expq[wr_i] = 8'hA5;
    wr_i++;
    step;
    wr_en = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R2", "ready after write", int'(tx_ready), 0);
    step;
    @(negedge clk);
    chk(tx_ready == 1'b1 && txd == 1'b0, "R3", "ready with start bit on line",
        int'({tx_ready, txd}), 2);
    drain;

    // R4: every byte at 1x, without and with parity
    for (int p = 0; p < 2; p++) begin
      par_en = p[0];
      cfg_par = p[0];
      for (int b = 0; b < 256; b++) send(b[7:0]);
      drain;
    end

    // R5: 16x and 64x (both codes)
    tick_div = 2;
    set_rate(2'b01);
    for (int b = 0; b < 16; b++) send(8'(b * 17 + 3));
    drain;
    set_rate(2'b10);
    send(8'h01);
    send(8'h80);
    send(8'h5A);
    drain;
    set_rate(2'b11);
    par_en = 1'b0;
    cfg_par = 1'b0;
    send(8'hC3);
    drain;

    // R9: sparse ticks, then no ticks at all
    tick_div = 3;
    set_rate(2'b01);
    send(8'h96);
    send(8'h69);
    drain;
    tick_div = 0;
    send(8'h3C);
    repeat (200) step;
    @(negedge clk);
    chk(txd == 1'b0 && !m_act, "R9", "start bit frozen without ticks", int'(txd), 0);
    tick_div = 1;
    drain;

    // R6: each gate closed in turn
    set_rate(2'b00);
    cts_n = 1'b1;
    send(8'h11);
    hold_check(300, "R6");
    cts_n = 1'b0;
    drain;
    tx_en = 1'b0;
    send(8'h22);
    hold_check(300, "R6");
    tx_en = 1'b1;
    drain;

    // R7: clear-to-send drops mid-character with a byte waiting
    set_rate(2'b01);
    send(8'hE7);
    send(8'h18);
    while (!(m_act && m_pos > 40)) step;
    cts_n = 1'b1;
    r0 = rd_i;
    while (rd_i == r0) step;
    hold_check(400, "R7");
    cts_n = 1'b0;
    drain;

    // R8: dropped write
    set_rate(2'b00);
    tx_en = 1'b0;
    send(8'h4D);
    wr_en = 1'b1;
    wr_data = 8'hB2;
    step;
    wr_en = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b1, "R8", "overrun after dropped write", int'(overrun), 1);
    chk(tx_ready == 1'b0, "R8", "buffer still full", int'(tx_ready), 0);
    tx_en = 1'b1;
    drain;
    chk(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);
    rst = 1'b1;
    step;
    step;
    rst = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b0, "R1", "overrun cleared by reset", int'(overrun), 0);

    // R1: reset in the middle of a 64x character
    step;
    set_rate(2'b10);
    send(8'hF0);
    while (!(m_act && m_pos > 100)) step;
    rst = 1'b1;
    step;
    @(negedge clk);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R1", "idle after mid-character reset",
        int'({txd, tx_ready}), 3);
    rd_i = wr_i;
    step;
    rst = 1'b0;
    step;
    send(8'h0F);
    drain;

    summary;
    finished = 1'b1;
    $finish;
  end
endmodule